// File: doc/BRIEF.md
# Byte-Wide Host Access Port

This block lets an external host reach a 16-bit-wide on-chip RAM through an 8-bit data path. The host selects one of four register views with a two-bit select, picks the upper or lower half of a 16-bit value with a byte-select input, and pulses a strobe. A word is always moved as two byte accesses. The upper half goes first and is parked in a byte latch. The RAM is touched only when the lower half is written, or when the upper half is read. The data view comes in two flavours: one advances the address register after each completed word and one leaves it alone. The host strobe is treated as already synchronous to the local clock. The bidirectional host bus is modelled as a separate input byte, an output byte and an output enable.

The RAM has one port, and the local processor shares it. A host access always wins the RAM for its single issue cycle, and a local request in that cycle is held off for one cycle. A two-bit control register can be reached from both sides. It carries one interrupt request toward the local processor and one toward the host. The requesting side sets a bit by writing 1 to it. The receiving side clears it by writing 1 to it.

Behaviour is organised as a four-state machine. IDLE is the only state that accepts a strobe, and the ready output is high only there. From IDLE, a read strobe on the upper half of a data view moves to RD_ISSUE. From IDLE, a write strobe on the lower half of a data view moves to WR_ISSUE. Every other strobe stays in IDLE. RD_ISSUE drives the RAM read and always moves to RD_CAPT. RD_CAPT stores the returned word and always moves back to IDLE. WR_ISSUE drives the RAM write, applies a pending increment, and always moves back to IDLE.

Top module: `hostport8`

## Requirements
- R1: While reset is low, hp_rdy, hp_irq and loc_irq are 0 and strobes have no effect; after reset the address register reads 0.
- R2: A data write with hp_hi=1 only loads the byte latch: it changes neither the RAM nor the address. The following write with hp_hi=0 writes {latch, byte} to the RAM at the address register.
- R3: hp_sel selects the view: 0 is control, 1 is address, 2 is data with increment, 3 is data without increment. For the address view, the word is committed on the hp_hi=0 write as {latch, byte}.
- R4: With hp_sel=2, the address register goes up by one after a lower-half write commits, and after a lower-half read. With hp_sel=3, it never changes.
- R5: A read with hp_hi=1 on a data view fetches the word at the address register and returns bits 15:8. The next read with hp_hi=0 returns bits 7:0 of the same word.
- R6: hp_rdy falls in the cycle after an accepted strobe that needs the RAM: for one cycle after a write, and for two cycles after a fetch. Strobes that arrive while hp_rdy is low are ignored.
- R7: In a host RAM issue cycle, a local request sees loc_gnt=0 and is granted in the next cycle. The local access then observes the host's write. loc_gnt is never high without loc_req.
- R8: A host write with hp_hi=0 to control, with bit 0 set, raises loc_irq. A local control write with bit 0 set clears it. If both happen in the same cycle, the set wins.
- R9: A local control write with bit 1 set raises hp_irq. A host control write with bit 1 set clears it, and a host write never raises it.
- R10: A control read with hp_hi=0 returns {6'b0, hp_irq, loc_irq}, and with hp_hi=1 it returns 0. An address read returns the zero-extended address, upper or lower byte.
- R11: hp_doe is 1 after an accepted read strobe and 0 after an accepted write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Local reset, active low |
| hp_cs | input | 1 | Host strobe, one cycle per byte access |
| hp_rw | input | 1 | 1 = host read, 0 = host write |
| hp_sel | input | 2 | Register view select |
| hp_hi | input | 1 | 1 = upper byte, 0 = lower byte |
| hp_din | input | 8 | Host write byte |
| hp_dout | output | 8 | Host read byte |
| hp_doe | output | 1 | Host bus output enable |
| hp_rdy | output | 1 | Host may strobe |
| hp_irq | output | 1 | Interrupt toward the host |
| loc_req | input | 1 | Local RAM request |
| loc_we | input | 1 | Local write enable |
| loc_addr | input | AW | Local RAM address |
| loc_wdata | input | WW | Local write word |
| loc_rdata | output | WW | Local read word, valid one cycle after grant |
| loc_gnt | output | 1 | Local request granted this cycle |
| loc_ctl_we | input | 1 | Local control write |
| loc_ctl_wdata | input | 2 | Local control write bits |
| loc_ctl_rdata | output | 2 | Control bits {hp_irq, loc_irq} |
| loc_irq | output | 1 | Interrupt toward the local processor |
| mem_en | output | 1 | RAM enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | WW | RAM write word |
| mem_rdata | input | WW | RAM read word, one cycle after enable |

## Verification
A wrong state machine state shows up in hp_rdy within one cycle of the strobe: ready stays high when it should drop, or stays low past the two-cycle fetch window. A wrong address register or byte latch only shows up at the next word transfer. It appears as a misplaced or mixed-up RAM word, which a local read-back catches. Sweeping a whole block of addresses, with both incrementing and fixed views, exposes an off-by-one after the first word. A broken arbitration shows up as loc_gnt being high in the host issue cycle, or as the local read returning the word from before the host write.

// File: rtl/hostport8_pkg.sv
package hostport8_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_ISSUE = 2'd1,
        ST_RD_CAPT  = 2'd2,
        ST_WR_ISSUE = 2'd3
    } hp_state_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DINC = 2'd2,
        SEL_DFIX = 2'd3
    } hp_sel_t;
endpackage

// File: rtl/hostport8_irq.sv
module hostport8_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [1:0] host_bits,
    input  logic       loc_we,
    input  logic [1:0] loc_bits,
    output logic       to_loc,
    output logic       to_host
);
    logic set_loc, clr_loc, set_host, clr_host;

    assign set_loc  = host_we & host_bits[0];
    assign clr_loc  = loc_we  & loc_bits[0];
    assign set_host = loc_we  & loc_bits[1];
    assign clr_host = host_we & host_bits[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_loc  <= 1'b0;
            to_host <= 1'b0;
        end else begin
            to_loc  <= (to_loc  & ~clr_loc)  | set_loc;
            to_host <= (to_host & ~clr_host) | set_host;
        end
    end
endmodule

// File: rtl/hostport8_arb.sv
module hostport8_arb #(
    parameter int AW = 8,
    parameter int WW = 16
) (
    input  logic          host_en,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [WW-1:0] host_wdata,
    input  logic          loc_req,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [WW-1:0] loc_wdata,
    output logic          loc_gnt,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata
);
    always_comb begin
        loc_gnt = loc_req & ~host_en;
        if (host_en) begin
            mem_en    = 1'b1;
            mem_we    = host_we;
            mem_addr  = host_addr;
            mem_wdata = host_wdata;
        end else begin
            mem_en    = loc_req;
            mem_we    = loc_req & loc_we;
            mem_addr  = loc_addr;
            mem_wdata = loc_wdata;
        end
    end
endmodule

// File: rtl/hostport8.sv
module hostport8
    import hostport8_pkg::*;
#(
    parameter int AW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hp_cs,
    input  logic          hp_rw,
    input  logic [1:0]    hp_sel,
    input  logic          hp_hi,
    input  logic [7:0]    hp_din,
    output logic [7:0]    hp_dout,
    output logic          hp_doe,
    output logic          hp_rdy,
    output logic          hp_irq,
    input  logic          loc_req,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [WW-1:0] loc_wdata,
    output logic [WW-1:0] loc_rdata,
    output logic          loc_gnt,
    input  logic          loc_ctl_we,
    input  logic [1:0]    loc_ctl_wdata,
    output logic [1:0]    loc_ctl_rdata,
    output logic          loc_irq,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic [WW-1:0] mem_rdata
);
    localparam int BW = WW / 2;

    hp_state_t     state_q, state_d;
    hp_sel_t       sel;
    logic          strobe, host_ctl_we, inc_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] hold_q;
    logic [WW-1:0] dreg_q, addr_ext;

    assign sel         = hp_sel_t'(hp_sel);
    assign hp_rdy      = rst_n && (state_q == ST_IDLE);
    assign strobe      = hp_cs && hp_rdy;
    assign host_ctl_we = strobe && !hp_rw && (sel == SEL_CTL) && !hp_hi;
    assign addr_ext    = WW'(addr_q);
    assign loc_rdata   = mem_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe && sel[1]) begin
                    if (hp_rw && hp_hi)        state_d = ST_RD_ISSUE;
                    else if (!hp_rw && !hp_hi) state_d = ST_WR_ISSUE;
                end
            end
            ST_RD_ISSUE: state_d = ST_RD_CAPT;
            ST_RD_CAPT:  state_d = ST_IDLE;
            ST_WR_ISSUE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            hold_q  <= '0;
            dreg_q  <= '0;
            hp_dout <= '0;
            hp_doe  <= 1'b0;
            inc_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (strobe) begin
                        hp_doe <= hp_rw;
                        if (hp_rw) begin
                            unique case (sel)
                                SEL_CTL:  hp_dout <= hp_hi ? 8'h00 : {6'b0, hp_irq, loc_irq};
                                SEL_ADDR: hp_dout <= hp_hi ? addr_ext[WW-1:BW] : addr_ext[BW-1:0];
                                SEL_DINC, SEL_DFIX: begin
                                    if (!hp_hi) begin
                                        hp_dout <= dreg_q[BW-1:0];
                                        if (sel == SEL_DINC) addr_q <= addr_q + 1'b1;
                                    end
                                end
                            endcase
                        end else begin
                            unique case (sel)
                                SEL_CTL: ;
                                SEL_ADDR: begin
                                    if (hp_hi) hold_q <= hp_din;
                                    else       addr_q <= AW'({hold_q, hp_din});
                                end
                                SEL_DINC, SEL_DFIX: begin
                                    if (hp_hi) hold_q <= hp_din;
                                    else begin
                                        dreg_q <= {hold_q, hp_din};
                                        inc_q  <= (sel == SEL_DINC);
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_RD_ISSUE: ;
                ST_RD_CAPT: begin
                    dreg_q  <= mem_rdata;
                    hp_dout <= mem_rdata[WW-1:BW];
                end
                ST_WR_ISSUE: begin
                    if (inc_q) addr_q <= addr_q + 1'b1;
                end
            endcase
        end
    end

    hostport8_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_ctl_we),
        .host_bits (hp_din[1:0]),
        .loc_we    (loc_ctl_we),
        .loc_bits  (loc_ctl_wdata),
        .to_loc    (loc_irq),
        .to_host   (hp_irq)
    );

    assign loc_ctl_rdata = {hp_irq, loc_irq};

    hostport8_arb #(.AW(AW), .WW(WW)) u_arb (
        .host_en    ((state_q == ST_RD_ISSUE) || (state_q == ST_WR_ISSUE)),
        .host_we    (state_q == ST_WR_ISSUE),
        .host_addr  (addr_q),
        .host_wdata (dreg_q),
        .loc_req    (loc_req),
        .loc_we     (loc_we),
        .loc_addr   (loc_addr),
        .loc_wdata  (loc_wdata),
        .loc_gnt    (loc_gnt),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: rtl/hostport8_chk.sv
module hostport8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hp_cs,
    input logic       hp_rw,
    input logic [1:0] hp_sel,
    input logic       hp_hi,
    input logic       hp_din0,
    input logic       hp_rdy,
    input logic       hp_irq,
    input logic       loc_irq,
    input logic       loc_req,
    input logic       loc_gnt,
    input logic       loc_ctl_we,
    input logic       loc_set_host,
    input logic       mem_en,
    input logic       mem_we
);
    always @(posedge clk) begin
        if (!rst_n) p_rdy_low_reset_r1: assert (!hp_rdy);
    end

    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_cs && hp_rdy && !hp_rw && hp_sel[1] && !hp_hi) |=> (mem_en && mem_we && !hp_rdy));

    p_hi_latch_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_cs && hp_rdy && !hp_rw && hp_sel[1] && hp_hi) |=> (hp_rdy && (!mem_en || loc_gnt)));

    p_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_cs && hp_rdy && hp_rw && hp_sel[1] && hp_hi) |=> (mem_en && !mem_we && !hp_rdy) ##1 !hp_rdy);

    p_host_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !loc_gnt) |-> (mem_en && !hp_rdy));

    p_stall_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && !loc_gnt) |=> (loc_gnt || !loc_req));

    p_gnt_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_gnt |-> loc_req);

    p_loc_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_irq) |-> $past(hp_cs && hp_rdy && !hp_rw && hp_sel == 2'b00 && !hp_hi && hp_din0));

    p_host_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hp_irq) |-> $past(loc_ctl_we && loc_set_host));
endmodule

bind hostport8 hostport8_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hp_cs        (hp_cs),
    .hp_rw        (hp_rw),
    .hp_sel       (hp_sel),
    .hp_hi        (hp_hi),
    .hp_din0      (hp_din[0]),
    .hp_rdy       (hp_rdy),
    .hp_irq       (hp_irq),
    .loc_irq      (loc_irq),
    .loc_req      (loc_req),
    .loc_gnt      (loc_gnt),
    .loc_ctl_we   (loc_ctl_we),
    .loc_set_host (loc_ctl_wdata[1]),
    .mem_en       (mem_en),
    .mem_we       (mem_we)
);

// File: tb/tb_hostport8.sv
`timescale 1ns/1ps
module tb_hostport8;
    localparam int AW = 8;
    localparam int WW = 16;
    localparam int NW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hp_cs = 1'b0, hp_rw = 1'b0, hp_hi = 1'b0;
    logic [1:0]    hp_sel = 2'd0;
    logic [7:0]    hp_din = 8'h00;
    logic [7:0]    hp_dout;
    logic          hp_doe, hp_rdy, hp_irq, loc_irq, loc_gnt;
    logic          loc_req = 1'b0, loc_we = 1'b0, loc_ctl_we = 1'b0;
    logic [AW-1:0] loc_addr = '0;
    logic [WW-1:0] loc_wdata = '0;
    logic [WW-1:0] loc_rdata;
    logic [1:0]    loc_ctl_wdata = 2'b00;
    logic [1:0]    loc_ctl_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic [WW-1:0] mem_rdata = '0;
    logic [WW-1:0] ram [0:(1<<AW)-1];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    hostport8 #(.AW(AW), .WW(WW)) dut (
        .clk(clk), .rst_n(rst_n), .hp_cs(hp_cs), .hp_rw(hp_rw), .hp_sel(hp_sel),
        .hp_hi(hp_hi), .hp_din(hp_din), .hp_dout(hp_dout), .hp_doe(hp_doe),
        .hp_rdy(hp_rdy), .hp_irq(hp_irq), .loc_req(loc_req), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .loc_gnt(loc_gnt), .loc_ctl_we(loc_ctl_we), .loc_ctl_wdata(loc_ctl_wdata),
        .loc_ctl_rdata(loc_ctl_rdata), .loc_irq(loc_irq), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [WW-1:0] pat(input int a);
        return WW'((a * 16'h0101) ^ 16'h5A3C);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hstrobe(input logic rw, input logic [1:0] sel, input logic hi, input logic [7:0] d);
        @(negedge clk);
        hp_cs = 1'b1; hp_rw = rw; hp_sel = sel; hp_hi = hi; hp_din = d;
        @(negedge clk);
        hp_cs = 1'b0;
        while (!hp_rdy) @(negedge clk);
    endtask

    task automatic hwr_word(input logic [1:0] sel, input logic [15:0] w);
        hstrobe(1'b0, sel, 1'b1, w[15:8]);
        hstrobe(1'b0, sel, 1'b0, w[7:0]);
    endtask

    task automatic hrd_word(input logic [1:0] sel, output logic [15:0] w);
        hstrobe(1'b1, sel, 1'b1, 8'h00);
        w[15:8] = hp_dout;
        hstrobe(1'b1, sel, 1'b0, 8'h00);
        w[7:0] = hp_dout;
    endtask

    task automatic lrd(input logic [AW-1:0] a, output logic [WW-1:0] w);
        @(negedge clk);
        loc_req = 1'b1; loc_we = 1'b0; loc_addr = a;
        @(negedge clk);
        loc_req = 1'b0;
        w = loc_rdata;
    endtask

    task automatic lctl(input logic [1:0] bits);
        @(negedge clk);
        loc_ctl_we = 1'b1; loc_ctl_wdata = bits;
        @(negedge clk);
        loc_ctl_we = 1'b0; loc_ctl_wdata = 2'b00;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [WW-1:0] lw;
        for (int i = 0; i < (1 << AW); i++) ram[i] = 16'hDEAD;

        // R1: reset holds port closed, strobe ignored
        @(negedge clk);
        hp_cs = 1'b1; hp_rw = 1'b0; hp_sel = 2'd1; hp_hi = 1'b0; hp_din = 8'h33;
        @(negedge clk);
        check(hp_rdy == 1'b0, "R1 rdy in reset", 32'(hp_rdy), 0);
        check(hp_irq == 1'b0 && loc_irq == 1'b0, "R1 irqs in reset", {hp_irq, loc_irq}, 0);
        hp_cs = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(hp_rdy == 1'b1, "R1 rdy after reset", 32'(hp_rdy), 1);
        hrd_word(2'd1, w);
        check(w == 16'h0000, "R1 address after reset", w, 0);

        // R3 R4: set address 0, sequential write sweep
        hwr_word(2'd1, 16'h0000);
        for (int a = 0; a < NW; a++) hwr_word(2'd2, pat(a));
        hrd_word(2'd1, w);
        check(w == 16'(NW), "R4 address after write sweep", w, NW);
        check(hp_doe == 1'b1, "R11 doe after read", 32'(hp_doe), 1);
        for (int a = 0; a < NW; a++) begin
            lrd(AW'(a), lw);
            check(lw == pat(a), "R2 word written at address", lw, pat(a));
        end

        // R5 R4: sequential read sweep
        hwr_word(2'd1, 16'h0000);
        check(hp_doe == 1'b0, "R11 doe after write", 32'(hp_doe), 0);
        for (int a = 0; a < NW; a++) begin
            hrd_word(2'd2, w);
            check(w == pat(a), "R5 sequential read word", w, pat(a));
        end
        hrd_word(2'd1, w);
        check(w == 16'(NW), "R4 address after read sweep", w, NW);

        // R4: fixed view keeps address
        hwr_word(2'd1, 16'h000A);
        hrd_word(2'd3, w);
        check(w == pat(10), "R5 fixed read", w, pat(10));
        hrd_word(2'd3, w);
        check(w == pat(10), "R4 fixed read repeat", w, pat(10));
        hwr_word(2'd3, 16'hBEEF);
        hrd_word(2'd1, w);
        check(w == 16'h000A, "R4 fixed view address unchanged", w, 16'h000A);
        lrd(AW'(10), lw);
        check(lw == 16'hBEEF, "R2 fixed write lands", lw, 16'hBEEF);

        // R2: upper byte alone does nothing visible
        hwr_word(2'd1, 16'h0014);
        hstrobe(1'b0, 2'd2, 1'b1, 8'h77);
        hrd_word(2'd1, w);
        check(w == 16'h0014, "R2 upper byte keeps address", w, 16'h0014);
        lrd(AW'(20), lw);
        check(lw == pat(20), "R2 upper byte keeps RAM", lw, pat(20));

        // R6: ready timing for fetch and commit
        @(negedge clk);
        hp_cs = 1'b1; hp_rw = 1'b1; hp_sel = 2'd3; hp_hi = 1'b1;
        @(negedge clk);
        hp_cs = 1'b0;
        check(hp_rdy == 1'b0, "R6 rdy low fetch cycle 1", 32'(hp_rdy), 0);
        hp_cs = 1'b1; hp_rw = 1'b0; hp_sel = 2'd1; hp_hi = 1'b0; hp_din = 8'h99;
        @(negedge clk);
        hp_cs = 1'b0;
        check(hp_rdy == 1'b0, "R6 rdy low fetch cycle 2", 32'(hp_rdy), 0);
        @(negedge clk);
        check(hp_rdy == 1'b1, "R6 rdy back after fetch", 32'(hp_rdy), 1);
        check(hp_dout == pat(20)[15:8], "R5 fetched upper byte", hp_dout, pat(20)[15:8]);
        hrd_word(2'd1, w);
        check(w == 16'h0014, "R6 strobe while busy ignored", w, 16'h0014);

        // R7: contention, host wins, local stalled once
        hstrobe(1'b0, 2'd3, 1'b1, 8'hC0);
        @(negedge clk);
        hp_cs = 1'b1; hp_rw = 1'b0; hp_sel = 2'd3; hp_hi = 1'b0; hp_din = 8'hDE;
        @(negedge clk);
        hp_cs = 1'b0;
        check(hp_rdy == 1'b0, "R6 rdy low commit", 32'(hp_rdy), 0);
        loc_req = 1'b1; loc_we = 1'b0; loc_addr = AW'(20);
        #0;
        check(loc_gnt == 1'b0, "R7 local stalled in host cycle", 32'(loc_gnt), 0);
        @(negedge clk);
        check(loc_gnt == 1'b1, "R7 local granted next cycle", 32'(loc_gnt), 1);
        check(hp_rdy == 1'b1, "R6 rdy after one commit cycle", 32'(hp_rdy), 1);
        @(negedge clk);
        loc_req = 1'b0;
        check(loc_rdata == 16'hC0DE, "R7 local sees host write", loc_rdata, 16'hC0DE);

        // R8 R9 R10: interrupt bits
        hstrobe(1'b0, 2'd0, 1'b0, 8'h01);
        check(loc_irq == 1'b1, "R8 host raises loc_irq", 32'(loc_irq), 1);
        hstrobe(1'b1, 2'd0, 1'b0, 8'h00);
        check(hp_dout == 8'h01, "R10 control read", hp_dout, 8'h01);
        hstrobe(1'b1, 2'd0, 1'b1, 8'h00);
        check(hp_dout == 8'h00, "R10 control upper byte", hp_dout, 8'h00);
        lctl(2'b01);
        check(loc_irq == 1'b0, "R8 local clears loc_irq", 32'(loc_irq), 0);
        hstrobe(1'b0, 2'd0, 1'b0, 8'h02);
        check(hp_irq == 1'b0, "R9 host cannot raise hp_irq", 32'(hp_irq), 0);
        lctl(2'b10);
        check(hp_irq == 1'b1, "R9 local raises hp_irq", 32'(hp_irq), 1);
        check(loc_ctl_rdata == 2'b10, "R10 local control view", loc_ctl_rdata, 2'b10);
        hstrobe(1'b1, 2'd0, 1'b0, 8'h00);
        check(hp_dout == 8'h02, "R10 control shows hp_irq", hp_dout, 8'h02);
        hstrobe(1'b0, 2'd0, 1'b0, 8'h02);
        check(hp_irq == 1'b0, "R9 host clears hp_irq", 32'(hp_irq), 0);
        // R8: simultaneous set and clear, set wins
        @(negedge clk);
        hp_cs = 1'b1; hp_rw = 1'b0; hp_sel = 2'd0; hp_hi = 1'b0; hp_din = 8'h01;
        loc_ctl_we = 1'b1; loc_ctl_wdata = 2'b01;
        @(negedge clk);
        hp_cs = 1'b0; loc_ctl_we = 1'b0; loc_ctl_wdata = 2'b00;
        check(loc_irq == 1'b1, "R8 set wins over clear", 32'(loc_irq), 1);

        // R1: reset during activity clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(loc_irq == 1'b0 && hp_rdy == 1'b0, "R1 reset clears", {loc_irq, hp_rdy}, 0);
        rst_n = 1'b1;
        hrd_word(2'd1, w);
        check(w == 16'h0000, "R1 address cleared", w, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule